// File: doc/BRIEF.md
# Three-Channel Compare-Match Timer

This block holds several independent up-counters, three by default, each as wide as the bus data path (16 bits by default). They sit behind a simple byte-addressed register bus. One shared start register holds a run bit for each channel. Each channel has a programmable prescaler, a selectable count edge, a selectable source that clears the counter, and a compare register. A compare match sets a sticky status flag, can raise an interrupt and can drive a compare output pin.

Software sets up a periodic tick as follows. It selects a divider and sets the clear source to "compare A". It loads the compare register with the period minus one, enables the interrupt and sets the channel's start bit. Each time the counter reaches the compare value, the flag is set and the counter wraps to zero. Software then acknowledges the event with a read of the status register followed by a zero write.

A channel may also use synchronous clear. Its counter then returns to zero whenever another running channel clears on its own compare match. This keeps counters aligned across channels.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset every register reads zero except compare A, which reads 0xFFFF. The pins `tmr_out` and `tmr_irq` are zero.
- R2: The shared start register sits at address 0x00. Channel n occupies the 16 bytes from 0x10*(n+1). Its offsets are: clear/edge/divider control 0, mode 1, pin control 2, interrupt enable 4 (bit 0), status 5 (bit 0 is the flag), counter 6 and compare A 8. Counter and compare A use the full 16-bit data word; the other registers use the low byte. Unmapped offsets and channels read zero. Read data appears on `bus_rdata` one clock after `bus_re`.
- R3: Start bit n runs channel n, and start bits above the channel count read zero. While the bit is clear, both the counter and the prescaler phase hold their values.
- R4: Control bits 2:0 select the divider: 0 is /1, 1 is /4, 2 is /16 and 3 is /64. Codes 4 to 7 do not advance the counter.
- R5: Control bits 4:3 select the edge: 0 rising, 1 falling, 2 both. Rising and falling count at the divided rate. "Both" doubles that rate for every divider above /1.
- R6: Control bits 7:5 set to 1 make the counter return to zero on the tick after the one on which it equals compare A. The period is therefore compare A plus one ticks.
- R7: The clear codes 0, 2, 5 and 6 never clear the counter, which wraps from 0xFFFF to 0.
- R8: A running channel with clear code 3 has its counter zeroed on any cycle in which another channel clears on its compare-A match.
- R9: The status flag (bit 0) is set on the tick on which the counter equals compare A. It is cleared only by a zero write to bit 0 after a read of the status register that returned the flag set. Writing 1, or writing 0 without that read, leaves the flag unchanged.
- R10: `tmr_irq[n]` is the channel's flag ANDed with interrupt-enable bit 0, registered one clock later.
- R11: The low nibble of the pin control register drives `tmr_out[n]`. Writing codes 1–3 forces the pin to 0 and writing codes 5–7 forces it to 1. On each match, codes 1 and 5 clear the pin, 2 and 6 set it, and 3 and 7 toggle it. Code 0 and codes 8 and above leave the pin unchanged, both on the write and on matches.
- R12: A bus write to the counter takes effect on that clock whether the channel is running or not. It takes priority over a tick in the same cycle.
- R13: Mode bits 6:0 read back as written and bit 7 reads zero. Any nonzero value in mode bits 3:0 halts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | CNT_W | Write data (low byte for byte registers) |
| bus_rdata | output | CNT_W | Registered read data |
| tmr_out | output | NCH | Compare output pin for each channel |
| tmr_irq | output | NCH | Compare-A interrupt for each channel |

## Verification
The bench measures count windows that are whole multiples of 64 enabled cycles, so that every divider and edge setting gives an exact tick count. A wrong divider code, or a "both edges" mode that fails to double, shows up as a wrong count. Compare-clear runs with random periods and lengths check that the result equals the run length modulo (compare+1); an off-by-one period drifts away from that. The prescaler-freeze test splits four /4 cycles over two runs; a prescaler that restarts when stopped yields zero ticks instead of one. The status tests write zero before any read and write one after a read. A flag that clears on either write drops the interrupt too early. A sync-slave started from a different value must match its master after the first clear.

// File: rtl/cmtu_pkg.sv
package cmtu_pkg;
  localparam int OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [OFF_W-1:0] OFF_MODE = 4'h1;
  localparam logic [OFF_W-1:0] OFF_PINC = 4'h2;
  localparam logic [OFF_W-1:0] OFF_IEN  = 4'h4;
  localparam logic [OFF_W-1:0] OFF_STS  = 4'h5;
  localparam logic [OFF_W-1:0] OFF_CNT  = 4'h6;
  localparam logic [OFF_W-1:0] OFF_CMPA = 4'h8;

  // counter clear source codes
  localparam logic [2:0] CLR_ON_A   = 3'd1;
  localparam logic [2:0] CLR_FOLLOW = 3'd3;

  // count edge codes
  localparam logic [1:0] EDGE_FALL = 2'd1;
  localparam logic [1:0] EDGE_BOTH = 2'd2;

  localparam logic [3:0] MODE_PLAIN = 4'd0;

  typedef struct packed {
    logic [2:0] clr;
    logic [1:0] edg;
    logic [2:0] div;
  } ctrl_t;
endpackage

// File: rtl/cmtu_prescaler.sv
module cmtu_prescaler
  import cmtu_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] div,
  input  logic [1:0] edg,
  output logic       tick
);
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] mask;
  logic             legal;
  logic             hit_rise;
  logic             hit_fall;
  logic             hit;

  // mask has 2*div low ones: /1, /4, /16, /64
  always_comb begin
    mask  = '0;
    legal = ~div[2];
    for (int b = 0; b < PRE_W; b++) begin
      if (b < 2 * int'(div[1:0])) mask[b] = 1'b1;
    end
  end

  assign hit_rise = ((phase & mask) == mask);
  assign hit_fall = (mask == '0) ? 1'b1 : ((phase & mask) == (mask >> 1));

  always_comb begin
    case (edg)
      EDGE_FALL: hit = hit_fall;
      EDGE_BOTH: hit = hit_rise | hit_fall;
      default:   hit = hit_rise;
    endcase
  end

  assign tick = en & legal & hit;

  always_ff @(posedge clk) begin
    if (rst)     phase <= '0;
    else if (en) phase <= phase + PRE_W'(1);
  end
endmodule

// File: rtl/cmtu_outpin.sv
module cmtu_outpin (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_code,
  input  logic [3:0] cur_code,
  input  logic       match,
  output logic       pin
);
  logic cfg_low;
  logic cfg_high;
  logic acts;

  assign cfg_low  = cfg_wr && (cfg_code == 4'd1 || cfg_code == 4'd2 || cfg_code == 4'd3);
  assign cfg_high = cfg_wr && (cfg_code == 4'd5 || cfg_code == 4'd6 || cfg_code == 4'd7);
  assign acts     = match && !cur_code[3] && (cur_code[1:0] != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else if (cfg_low)  pin <= 1'b0;
    else if (cfg_high) pin <= 1'b1;
    else if (acts) begin
      case (cur_code[1:0])
        2'd1:    pin <= 1'b0;
        2'd2:    pin <= 1'b1;
        default: pin <= ~pin;
      endcase
    end
  end
endmodule

// File: rtl/cmtu_channel.sv
module cmtu_channel
  import cmtu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] off,
  input  logic [CNT_W-1:0] wdata,
  input  logic             sync_clr,
  output logic [CNT_W-1:0] rd_word,
  output logic             clr_evt,
  output logic             match_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tout,
  output logic             irq
);
  ctrl_t            ctrl;
  logic [6:0]       mode;
  logic [7:0]       pinc;
  logic             ien;
  logic             flag;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmpa;

  logic active, tick, match, sync_hit, ack;
  logic w_ctrl, w_mode, w_pinc, w_ien, w_sts, w_cnt, w_cmpa, r_sts;

  assign w_ctrl = wr_en && off == OFF_CTRL;
  assign w_mode = wr_en && off == OFF_MODE;
  assign w_pinc = wr_en && off == OFF_PINC;
  assign w_ien  = wr_en && off == OFF_IEN;
  assign w_sts  = wr_en && off == OFF_STS;
  assign w_cnt  = wr_en && off == OFF_CNT;
  assign w_cmpa = wr_en && off == OFF_CMPA;
  assign r_sts  = rd_en && off == OFF_STS;

  assign active = run && (mode[3:0] == MODE_PLAIN);

  cmtu_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (active),
    .div  (ctrl.div),
    .edg  (ctrl.edg),
    .tick (tick)
  );

  assign match    = tick && (cnt == cmpa);
  assign clr_evt  = match && (ctrl.clr == CLR_ON_A);
  assign sync_hit = active && (ctrl.clr == CLR_FOLLOW) && sync_clr;
  assign ack      = w_sts && armed && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      mode  <= '0;
      pinc  <= '0;
      ien   <= 1'b0;
      cmpa  <= '1;
      cnt   <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (w_ctrl) ctrl <= wdata[7:0];
      if (w_mode) mode <= wdata[6:0];
      if (w_pinc) pinc <= wdata[7:0];
      if (w_ien)  ien  <= wdata[0];
      if (w_cmpa) cmpa <= wdata;

      if (w_cnt)                     cnt <= wdata;
      else if (clr_evt || sync_hit)  cnt <= '0;
      else if (tick)                 cnt <= cnt + CNT_W'(1);

      if (match)    flag <= 1'b1;
      else if (ack) flag <= 1'b0;

      if (ack)                armed <= 1'b0;
      else if (r_sts && flag) armed <= 1'b1;

      irq <= flag & ien;
    end
  end

  always_comb begin
    rd_word = '0;
    case (off)
      OFF_CTRL: rd_word[7:0] = ctrl;
      OFF_MODE: rd_word[6:0] = mode;
      OFF_PINC: rd_word[7:0] = pinc;
      OFF_IEN:  rd_word[0]   = ien;
      OFF_STS:  rd_word[0]   = flag;
      OFF_CNT:  rd_word      = cnt;
      OFF_CMPA: rd_word      = cmpa;
      default:  rd_word      = '0;
    endcase
  end

  cmtu_outpin u_pin (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (w_pinc),
    .cfg_code (wdata[3:0]),
    .cur_code (pinc[3:0]),
    .match    (match),
    .pin      (tout)
  );

  assign match_o = match;
  assign flag_o  = flag;
  assign cnt_o   = cnt;
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import cmtu_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    tmr_out,
  output logic [NCH-1:0]    tmr_irq
);
  localparam int GRP_W = ADDR_W - OFF_W;

  logic [GRP_W-1:0]            grp;
  logic [OFF_W-1:0]            off;
  logic                        start_sel;
  logic [NCH-1:0]              run_q;
  logic [NCH-1:0]              ch_sel;
  logic [NCH-1:0]              clr_v;
  logic [NCH-1:0]              match_v;
  logic [NCH-1:0]              flag_v;
  logic [NCH-1:0][CNT_W-1:0]   rd_v;
  logic [NCH-1:0][CNT_W-1:0]   cnt_v;
  logic [CNT_W-1:0]            rd_mux;

  assign grp       = bus_addr[ADDR_W-1:OFF_W];
  assign off       = bus_addr[OFF_W-1:0];
  assign start_sel = (grp == '0) && (off == '0);

  always_ff @(posedge clk) begin
    if (rst)                      run_q <= '0;
    else if (bus_we && start_sel) run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [NCH-1:0] others;
    assign ch_sel[i] = (grp == GRP_W'(i + 1));
    assign others    = clr_v & ~(NCH'(1) << i);

    cmtu_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .run      (run_q[i]),
      .wr_en    (bus_we && ch_sel[i]),
      .rd_en    (bus_re && ch_sel[i]),
      .off      (off),
      .wdata    (bus_wdata),
      .sync_clr (|others),
      .rd_word  (rd_v[i]),
      .clr_evt  (clr_v[i]),
      .match_o  (match_v[i]),
      .flag_o   (flag_v[i]),
      .cnt_o    (cnt_v[i]),
      .tout     (tmr_out[i]),
      .irq      (tmr_irq[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel[i]) rd_mux = rd_mux | rd_v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= start_sel ? CNT_W'(run_q) : rd_mux;
  end
endmodule

// File: rtl/cmp_timer_unit_chk.sv
module cmp_timer_unit_chk #(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_we,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      wbit0,
  input logic [NCH-1:0]            run_q,
  input logic [NCH-1:0][CNT_W-1:0] cnt_v,
  input logic [NCH-1:0]            flag_v,
  input logic [NCH-1:0]            match_v,
  input logic [NCH-1:0]            tmr_out,
  input logic [NCH-1:0]            tmr_irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'((i + 1) * 16);
    logic wr_cnt, wr_sts, wr_pinc;
    assign wr_cnt  = bus_we && bus_addr == BASE + ADDR_W'(6);
    assign wr_sts  = bus_we && bus_addr == BASE + ADDR_W'(5);
    assign wr_pinc = bus_we && bus_addr == BASE + ADDR_W'(2);

    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (rst)
      (!run_q[i] && !wr_cnt) |=> $stable(cnt_v[i]));

    a_r9_flag_rises_on_match: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_v[i]) |-> $past(match_v[i]));

    a_r9_flag_falls_on_zero_write: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_v[i]) |-> $past(wr_sts && !wbit0));

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
      tmr_irq[i] |-> $past(flag_v[i]));

    a_r11_pin_has_cause: assert property (@(posedge clk) disable iff (rst)
      !$stable(tmr_out[i]) |-> $past(match_v[i] || wr_pinc));
  end
endmodule

bind cmp_timer_unit cmp_timer_unit_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .wbit0    (bus_wdata[0]),
  .run_q    (run_q),
  .cnt_v    (cnt_v),
  .flag_v   (flag_v),
  .match_v  (match_v),
  .tmr_out  (tmr_out),
  .tmr_irq  (tmr_irq)
);

// File: tb/cmp_timer_unit_tb.sv
module cmp_timer_unit_tb;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NCH-1:0] tmr_out;
  logic [NCH-1:0] tmr_irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_timer_unit #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_out(tmr_out), .tmr_irq(tmr_irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ra(int ch, int off);
    return 8'((ch + 1) * 16 + off);
  endfunction

  function automatic int exp_ticks(int dv, int ed, int m);
    int n, t;
    if (dv > 3) return 0;
    n = 1 << (2 * dv);
    t = m / n;
    if (ed == 2 && n > 1) t = t * 2;
    return t;
  endfunction

  task automatic wr(logic [7:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_win(logic [7:0] mask, int m);
    wr(8'h00, 16'(mask));
    repeat (m - 1) @(negedge clk);
    wr(8'h00, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    @(negedge clk);
    do_reset();

    // R1 reset state
    rdchk("R1 ctrl", ra(0, 0), 16'h0000);
    rdchk("R1 cmpa", ra(1, 8), 16'hFFFF);
    rdchk("R1 start", 8'h00, 16'h0000);
    rdchk("R1 status", ra(2, 5), 16'h0000);
    check("R1 pins", {13'b0, tmr_out}, 16'h0000);
    check("R1 irq", {13'b0, tmr_irq}, 16'h0000);

    // R2 address map
    wr(ra(2, 8), 16'hABCD);
    rdchk("R2 other ch cmpa", ra(1, 8), 16'hFFFF);
    rdchk("R2 ch2 cmpa", ra(2, 8), 16'hABCD);
    wr(ra(0, 4), 16'h0001);
    rdchk("R2 ien", ra(0, 4), 16'h0001);
    rdchk("R2 hole", ra(0, 3), 16'h0000);
    rdchk("R2 no channel", 8'h40, 16'h0000);
    wr(ra(1, 2), 16'h009C);
    rdchk("R2 pin ctrl", ra(1, 2), 16'h009C);
    check("R11 code 12 no drive", {15'b0, tmr_out[1]}, 16'h0000);

    // R3 start register width and freezing
    wr(8'h00, 16'h00FF);
    rdchk("R3 start bits", 8'h00, 16'h0007);
    wr(8'h00, 16'h0000);
    do_reset();
    wr(ra(0, 0), 16'h0001);
    run_win(8'h01, 2);
    run_win(8'h01, 2);
    rdchk("R3 prescaler phase held", ra(0, 6), 16'h0001);
    do_reset();
    run_win(8'h01, 10);
    rdchk("R3 count", ra(0, 6), 16'd10);
    repeat (20) @(negedge clk);
    rdchk("R3 frozen", ra(0, 6), 16'd10);

    // R4 / R5 directed
    do_reset();
    wr(ra(1, 0), 16'h0005);
    run_win(8'h02, 64);
    rdchk("R4 reserved divider", ra(1, 6), 16'h0000);
    do_reset();
    wr(ra(2, 0), 16'h0011);
    run_win(8'h04, 64);
    rdchk("R5 both edges /4", ra(2, 6), 16'd32);

    // R4 / R5 random windows
    for (int it = 0; it < 14; it++) begin
      int ch, dv, ed, m;
      ch = int'($urandom % 3);
      dv = int'($urandom % 8);
      ed = int'($urandom % 3);
      m  = 64 * (1 + int'($urandom % 3));
      do_reset();
      wr(ra(ch, 0), 16'((ed << 3) | dv));
      run_win(8'(1 << ch), m);
      rdchk("R4 R5 divided count", ra(ch, 6), 16'(exp_ticks(dv, ed, m)));
    end

    // R6 random compare-A periods, R9 flag
    for (int it = 0; it < 10; it++) begin
      int c, m;
      c = 1 + int'($urandom % 40);
      m = 1 + int'($urandom % 200);
      do_reset();
      wr(ra(0, 0), 16'h0020);
      wr(ra(0, 8), 16'(c));
      run_win(8'h01, m);
      rdchk("R6 wrap count", ra(0, 6), 16'(m % (c + 1)));
      rdchk("R9 flag after run", ra(0, 5), (m > c) ? 16'h0001 : 16'h0000);
    end

    // R7 non-clearing codes
    do_reset();
    wr(ra(0, 0), 16'h0040);
    wr(ra(0, 8), 16'd5);
    run_win(8'h01, 20);
    rdchk("R7 code 2 no clear", ra(0, 6), 16'd20);
    do_reset();
    wr(ra(1, 0), 16'h00C0);
    wr(ra(1, 8), 16'd3);
    wr(ra(1, 6), 16'hFFFE);
    run_win(8'h02, 5);
    rdchk("R7 code 6 wraps", ra(1, 6), 16'd3);

    // R8 synchronous clear
    do_reset();
    wr(ra(0, 0), 16'h0020);
    wr(ra(0, 8), 16'd9);
    wr(ra(1, 0), 16'h0060);
    wr(ra(1, 6), 16'd100);
    wr(ra(2, 0), 16'h0060);
    wr(ra(2, 6), 16'd50);
    run_win(8'h03, 25);
    rdchk("R6 master", ra(0, 6), 16'd5);
    rdchk("R8 follower", ra(1, 6), 16'd5);
    rdchk("R8 stopped follower", ra(2, 6), 16'd50);

    // R9 R10 R11 flag, interrupt, pins
    do_reset();
    for (int ch = 0; ch < 3; ch++) begin
      wr(ra(ch, 0), 16'h0020);
      wr(ra(ch, 8), 16'd3);
    end
    wr(ra(0, 4), 16'h0001);
    wr(ra(0, 2), 16'h0005);
    check("R11 init high", {15'b0, tmr_out[0]}, 16'h0001);
    wr(ra(1, 2), 16'h0003);
    check("R11 init low", {15'b0, tmr_out[1]}, 16'h0000);
    wr(ra(2, 2), 16'h0006);
    wr(ra(2, 2), 16'h0000);
    check("R11 code 0 retains", {15'b0, tmr_out[2]}, 16'h0001);
    wr(ra(2, 2), 16'h0009);
    run_win(8'h07, 14);
    @(negedge clk);
    check("R11 clear on match", {15'b0, tmr_out[0]}, 16'h0000);
    check("R11 toggle x3", {15'b0, tmr_out[1]}, 16'h0001);
    check("R11 capture code no action", {15'b0, tmr_out[2]}, 16'h0001);
    check("R10 irq enabled", {15'b0, tmr_irq[0]}, 16'h0001);
    check("R10 irq masked", {15'b0, tmr_irq[1]}, 16'h0000);
    wr(ra(1, 4), 16'h0001);
    @(negedge clk);
    check("R10 irq after enable", {15'b0, tmr_irq[1]}, 16'h0001);
    wr(ra(0, 5), 16'h0000);
    @(negedge clk);
    check("R9 zero write before read ignored", {15'b0, tmr_irq[0]}, 16'h0001);
    rdchk("R9 status read", ra(0, 5), 16'h0001);
    wr(ra(0, 5), 16'h0001);
    @(negedge clk);
    check("R9 one write ignored", {15'b0, tmr_irq[0]}, 16'h0001);
    wr(ra(0, 5), 16'h0000);
    @(negedge clk);
    check("R10 irq drops", {15'b0, tmr_irq[0]}, 16'h0000);
    rdchk("R9 flag cleared", ra(0, 5), 16'h0000);

    // R12 counter writes
    do_reset();
    wr(ra(0, 6), 16'h1234);
    rdchk("R12 write stopped", ra(0, 6), 16'h1234);
    wr(8'h00, 16'h0001);
    wr(ra(0, 6), 16'h1000);
    wr(8'h00, 16'h0000);
    rdchk("R12 write running", ra(0, 6), 16'h1001);

    // R13 mode register
    do_reset();
    wr(ra(0, 1), 16'h00FF);
    rdchk("R13 mode readback", ra(0, 1), 16'h007F);
    wr(ra(0, 1), 16'h0002);
    run_win(8'h01, 10);
    rdchk("R13 halted", ra(0, 6), 16'h0000);
    wr(ra(0, 1), 16'h0070);
    run_win(8'h01, 10);
    rdchk("R13 buffer bits only", ra(0, 6), 16'd10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule